// File: doc/BRIEF.md
# Programmable Timer Channel with Compare Interrupt

This block is one 32-bit timer channel. Software controls it through a small synchronous register bus. A free-running divider turns the clock into prescaled ticks. On each tick, the counter moves up, down, or back and forth between zero and a programmable period. It does this only while the channel is enabled, running and the `count_en` input is high. The channel raises a terminal-count event when the count wraps or turns, and a compare event when it lands on the compare value. Both events feed an interrupt block with raw, force, mask and masked views, and an `irq` line.

Enable has set and clear aliases, so software never needs a read-modify-write. Start, stop and capture commands act once, in the cycle they are written. The reload command is held pending until the next prescaled tick of an enabled channel. Software polls it until it reads 0. A one-shot option halts the channel at its first terminal count.

Top module: `tcnt_channel`

## Requirements
- R1: Register bus: a write takes effect at the clock edge where `bus_wr` is high, and a read returns data one cycle after `bus_rd` with `bus_rvalid` high. The byte offsets are:
  - enable 0x00, enable-set 0x04, enable-clear 0x08
  - command 0x0C, config 0x10, status 0x14
  - count 0x18, compare 0x1C, period 0x20, capture 0x24
  - irq-raw 0x28, irq-set 0x2C, irq-mask 0x30, irq-masked 0x34
- R2: Writing bit 0 = 1 to enable-set turns the channel on, and writing bit 0 = 1 to enable-clear turns it off. Enable, enable-set and enable-clear all read back the enable state at bit 0.
- R3: Command bit 0 (reload) reads 1 while pending. It is applied on the next prescaled tick while enabled: the count is loaded with 0, or with the period when counting down, and running is set. The bit then reads 0.
- R4: The count changes only on a prescaled tick while the channel is enabled, running and `count_en` is high.
- R5: With config bits [5:4] = 0 (up), the count rises to the period, then goes to 0 and raises terminal count.
- R6: With config bits [5:4] = 1 (down), the count falls to 0, then goes to the period and raises terminal count. Status bit 0 reads 1.
- R7: Config bits [5:4] = 2 or 3 select up/down counting, which turns at the period and at 0. Terminal count is raised at 0 in both modes, and also at the period in mode 3. Status bit 0 shows the current direction (1 = down).
- R8: Config bits [2:0] = n make one prescaled tick every 2^n clocks (n = 0 to 7).
- R9: Irq-raw bit 1 is set on the step at which the count becomes equal to the compare value.
- R10: Irq-raw bit 0 is terminal count and bit 1 is compare match. Writing 1 to an irq-raw bit clears it, and writing 1 to an irq-set bit sets it. Irq-masked reads irq-raw AND irq-mask, and `irq` is high when any masked bit is set.
- R11: With config bit 8 set (one-shot), the first terminal count holds the count and clears running.
- R12: Command bit 1 sets running, and command bit 2 clears it (stop wins). Status bit 31 reads running.
- R13: Command bit 3 copies the current count into capture. The count register may be written directly.
- R14: After reset the following hold:
  - disabled and stopped, with count 0 and config 0
  - period and compare all ones
  - interrupt state and mask clear, `irq` low

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| count_en | input | 1 | External count enable |
| irq | output | 1 | Interrupt, any masked cause set |

## Verification
Two cases are hardest to reach from the ports. One is the pending state of reload, because an enabled channel at divide-by-1 consumes it in the next cycle. The bench disables the channel first, issues the reload, and reads the command register before re-enabling. The other is the prescaler's phase, which is not visible at the ports. So tests at divide-by-4 and divide-by-128 hold `count_en` high for an exact multiple of the division. This makes the step count independent of where the divider stands.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

    localparam int ADDR_W = 8;
    localparam int PRE_W  = 3;
    localparam int DIV_W  = (1 << PRE_W) - 1;

    localparam logic [ADDR_W-1:0] OFS_ENA      = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ENA_SET  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ENA_CLR  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CMD      = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CFG      = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT     = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_COUNT    = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CMP      = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_PER      = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CAPT     = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_IRQ_RAW  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_IRQ_SET  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_IRQ_MASK = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_IRQ_MSKD = 8'h34;

    localparam int CMD_RELOAD = 0;
    localparam int CMD_START  = 1;
    localparam int CMD_STOP   = 2;
    localparam int CMD_CAPT   = 3;

    localparam int CFG_PRE_LSB  = 0;
    localparam int CFG_MODE_LSB = 4;
    localparam int CFG_ONESHOT  = 8;

    localparam int IRQ_TC    = 0;
    localparam int IRQ_MATCH = 1;
    localparam int IRQ_W     = 2;

    typedef enum logic [1:0] {
        MODE_UP       = 2'd0,
        MODE_DOWN     = 2'd1,
        MODE_UPDN_LOW = 2'd2,
        MODE_UPDN_ALL = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic             oneshot;
        cnt_mode_e        mode;
        logic [PRE_W-1:0] presc;
    } cfg_t;

    typedef struct packed {
        logic match;
        logic tc;
    } evt_t;

    function automatic logic is_updn(input cnt_mode_e m);
        return (m == MODE_UPDN_LOW) || (m == MODE_UPDN_ALL);
    endfunction

    function automatic cfg_t unpack_cfg(input logic [31:0] w);
        cfg_t c;
        c.presc   = w[CFG_PRE_LSB +: PRE_W];
        c.mode    = cnt_mode_e'(w[CFG_MODE_LSB +: 2]);
        c.oneshot = w[CFG_ONESHOT];
        return c;
    endfunction

    function automatic logic [31:0] pack_cfg(input cfg_t c);
        logic [31:0] w;
        w = '0;
        w[CFG_PRE_LSB +: PRE_W] = c.presc;
        w[CFG_MODE_LSB +: 2]    = c.mode;
        w[CFG_ONESHOT]          = c.oneshot;
        return w;
    endfunction

endpackage

// File: rtl/tcnt_prescale.sv
module tcnt_prescale
    import tcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PRE_W-1:0] sel,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] mask;

    always_comb begin
        span = ((DIV_W+1)'(1) << sel) - (DIV_W+1)'(1);
        mask = span[DIV_W-1:0];
        tick = en && ((phase_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/tcnt_core.sv
module tcnt_core
    import tcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] compare,
    input  logic             tick,
    input  logic             count_en,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             reload_pend,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] counter,
    output logic             dir_down,
    output logic             running,
    output logic             reload_done,
    output evt_t             evt
);

    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             dirq, dirq_nxt;
    logic             run_q;
    logic             step, wrap;

    assign reload_done = en && tick && reload_pend && !cnt_wr;
    assign step        = en && run_q && count_en && tick && !cnt_wr && !reload_done;

    always_comb begin
        cnt_nxt  = cnt_q;
        dirq_nxt = dirq;
        wrap     = 1'b0;
        unique case (cfg.mode)
            MODE_UP: begin
                if (cnt_q >= period) begin
                    cnt_nxt = '0;
                    wrap    = 1'b1;
                end else begin
                    cnt_nxt = cnt_q + CNT_W'(1);
                end
            end
            MODE_DOWN: begin
                if (cnt_q == '0) begin
                    cnt_nxt = period;
                    wrap    = 1'b1;
                end else begin
                    cnt_nxt = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                if (!dirq) begin
                    if (cnt_q >= period) begin
                        dirq_nxt = 1'b1;
                        cnt_nxt  = (period == '0) ? '0 : period - CNT_W'(1);
                        wrap     = (cfg.mode == MODE_UPDN_ALL);
                    end else begin
                        cnt_nxt = cnt_q + CNT_W'(1);
                    end
                end else begin
                    if (cnt_q == '0) begin
                        dirq_nxt = 1'b0;
                        cnt_nxt  = (period == '0) ? '0 : CNT_W'(1);
                        wrap     = 1'b1;
                    end else begin
                        cnt_nxt = cnt_q - CNT_W'(1);
                    end
                end
            end
        endcase
        if (wrap && cfg.oneshot) begin
            cnt_nxt  = cnt_q;
            dirq_nxt = dirq;
        end
    end

    always_comb begin
        evt.tc    = step && wrap;
        evt.match = step && (cnt_nxt != cnt_q) && (cnt_nxt == compare);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dirq  <= 1'b0;
            run_q <= 1'b0;
        end else begin
            if (cnt_wr) begin
                cnt_q <= cnt_wdata;
            end else if (reload_done) begin
                cnt_q <= (cfg.mode == MODE_DOWN) ? period : '0;
            end else if (step) begin
                cnt_q <= cnt_nxt;
            end

            if (reload_done) begin
                dirq <= 1'b0;
            end else if (step) begin
                dirq <= dirq_nxt;
            end

            if (stop_req) begin
                run_q <= 1'b0;
            end else if (start_req || reload_done) begin
                run_q <= 1'b1;
            end else if (evt.tc && cfg.oneshot) begin
                run_q <= 1'b0;
            end
        end
    end

    assign counter  = cnt_q;
    assign running  = run_q;
    assign dir_down = (cfg.mode == MODE_DOWN) || (is_updn(cfg.mode) && dirq);

endmodule

// File: rtl/tcnt_regs.sv
module tcnt_regs
    import tcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic [CNT_W-1:0]  counter,
    input  logic              dir_down,
    input  logic              running,
    input  logic              reload_done,
    input  evt_t              evt,
    output logic              en,
    output cfg_t              cfg,
    output logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  compare,
    output logic              start_req,
    output logic              stop_req,
    output logic              reload_pend,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic [IRQ_W-1:0]  irq_raw,
    output logic [IRQ_W-1:0]  irq_mask,
    output logic              irq
);

    logic              en_q, pend_q;
    cfg_t              cfg_q;
    logic [CNT_W-1:0]  per_q, cmp_q, capt_q, rd_mux;
    logic [IRQ_W-1:0]  raw_q, mask_q, hw_set;
    logic              cmd_wr;

    function automatic logic hit(input logic [ADDR_W-1:0] ofs);
        return bus_wr && (bus_addr == ofs);
    endfunction

    assign cmd_wr    = hit(OFS_CMD);
    assign start_req = cmd_wr && bus_wdata[CMD_START];
    assign stop_req  = cmd_wr && bus_wdata[CMD_STOP];
    assign cnt_wr    = hit(OFS_COUNT);
    assign cnt_wdata = bus_wdata;

    always_comb begin
        hw_set            = '0;
        hw_set[IRQ_TC]    = evt.tc;
        hw_set[IRQ_MATCH] = evt.match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
            cfg_q  <= unpack_cfg(32'd0);
            per_q  <= '1;
            cmp_q  <= '1;
            capt_q <= '0;
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            if (hit(OFS_ENA)) begin
                en_q <= bus_wdata[0];
            end else if (hit(OFS_ENA_SET) && bus_wdata[0]) begin
                en_q <= 1'b1;
            end else if (hit(OFS_ENA_CLR) && bus_wdata[0]) begin
                en_q <= 1'b0;
            end

            if (cmd_wr && bus_wdata[CMD_RELOAD]) begin
                pend_q <= 1'b1;
            end else if (reload_done) begin
                pend_q <= 1'b0;
            end

            if (cmd_wr && bus_wdata[CMD_CAPT]) begin
                capt_q <= counter;
            end

            if (hit(OFS_CFG))      cfg_q  <= unpack_cfg(32'(bus_wdata));
            if (hit(OFS_PER))      per_q  <= bus_wdata;
            if (hit(OFS_CMP))      cmp_q  <= bus_wdata;
            if (hit(OFS_IRQ_MASK)) mask_q <= bus_wdata[IRQ_W-1:0];

            raw_q <= (raw_q & ~(hit(OFS_IRQ_RAW) ? bus_wdata[IRQ_W-1:0] : '0))
                   | (hit(OFS_IRQ_SET) ? bus_wdata[IRQ_W-1:0] : '0)
                   | hw_set;
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_ENA, OFS_ENA_SET, OFS_ENA_CLR: rd_mux[0] = en_q;
            OFS_CMD:      rd_mux[CMD_RELOAD] = pend_q;
            OFS_CFG:      rd_mux = CNT_W'(pack_cfg(cfg_q));
            OFS_STAT: begin
                rd_mux[0]       = dir_down;
                rd_mux[CNT_W-1] = running;
            end
            OFS_COUNT:    rd_mux = counter;
            OFS_CMP:      rd_mux = cmp_q;
            OFS_PER:      rd_mux = per_q;
            OFS_CAPT:     rd_mux = capt_q;
            OFS_IRQ_RAW:  rd_mux[IRQ_W-1:0] = raw_q;
            OFS_IRQ_MASK: rd_mux[IRQ_W-1:0] = mask_q;
            OFS_IRQ_MSKD: rd_mux[IRQ_W-1:0] = raw_q & mask_q;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end

    assign en          = en_q;
    assign cfg         = cfg_q;
    assign period      = per_q;
    assign compare     = cmp_q;
    assign reload_pend = pend_q;
    assign irq_raw     = raw_q;
    assign irq_mask    = mask_q;
    assign irq         = |(raw_q & mask_q);

endmodule

// File: rtl/tcnt_channel.sv
module tcnt_channel
    import tcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic              count_en,
    output logic              irq
);

    logic             en, tick, running, dir_down, reload_done, reload_pend;
    logic             start_req, stop_req, cnt_wr;
    logic [CNT_W-1:0] counter, period, compare, cnt_wdata;
    logic [IRQ_W-1:0] irq_raw, irq_mask;
    cfg_t             cfg;
    evt_t             evt;

    tcnt_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .sel  (cfg.presc),
        .tick (tick)
    );

    tcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .cfg         (cfg),
        .period      (period),
        .compare     (compare),
        .tick        (tick),
        .count_en    (count_en),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .reload_pend (reload_pend),
        .cnt_wr      (cnt_wr),
        .cnt_wdata   (cnt_wdata),
        .counter     (counter),
        .dir_down    (dir_down),
        .running     (running),
        .reload_done (reload_done),
        .evt         (evt)
    );

    tcnt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_rvalid  (bus_rvalid),
        .counter     (counter),
        .dir_down    (dir_down),
        .running     (running),
        .reload_done (reload_done),
        .evt         (evt),
        .en          (en),
        .cfg         (cfg),
        .period      (period),
        .compare     (compare),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .reload_pend (reload_pend),
        .cnt_wr      (cnt_wr),
        .cnt_wdata   (cnt_wdata),
        .irq_raw     (irq_raw),
        .irq_mask    (irq_mask),
        .irq         (irq)
    );

endmodule

// File: rtl/tcnt_channel_chk.sv
module tcnt_channel_chk
    import tcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic              count_en,
    input logic              en,
    input logic              running,
    input logic              reload_pend,
    input logic              reload_done,
    input logic              start_req,
    input logic              cnt_wr,
    input logic [CNT_W-1:0]  counter,
    input logic [CNT_W-1:0]  compare,
    input cfg_t              cfg,
    input evt_t              evt,
    input logic [IRQ_W-1:0]  irq_raw
);

    a_r2_set_enables: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_ENA_SET && bus_wdata[0]) |=> en);

    a_r2_clr_disables: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_ENA_CLR && bus_wdata[0]) |=> !en);

    a_r3_pend_drops: assert property (@(posedge clk) disable iff (rst)
        (reload_done && !(bus_wr && bus_addr == OFS_CMD && bus_wdata[CMD_RELOAD]))
        |=> !reload_pend);

    a_r4_count_holds: assert property (@(posedge clk) disable iff (rst)
        (!(en && running && count_en) && !cnt_wr && !reload_done) |=> $stable(counter));

    a_r5_up_wraps_to_zero: assert property (@(posedge clk) disable iff (rst)
        (evt.tc && cfg.mode == MODE_UP && !cfg.oneshot) |=> (counter == '0));

    a_r9_match_value: assert property (@(posedge clk) disable iff (rst)
        evt.match |=> (counter == $past(compare)));

    a_r10_tc_latched: assert property (@(posedge clk) disable iff (rst)
        evt.tc |=> irq_raw[IRQ_TC]);

    a_r11_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
        (evt.tc && cfg.oneshot && !start_req) |=> !running);

endmodule

bind tcnt_channel tcnt_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .count_en    (count_en),
    .en          (en),
    .running     (running),
    .reload_pend (reload_pend),
    .reload_done (reload_done),
    .start_req   (start_req),
    .cnt_wr      (cnt_wr),
    .counter     (counter),
    .compare     (compare),
    .cfg         (cfg),
    .evt         (evt),
    .irq_raw     (irq_raw)
);

// File: tb/tcnt_channel_tb.sv
module tcnt_channel_tb;

    localparam logic [7:0] A_ENA = 8'h00, A_ESET = 8'h04, A_ECLR = 8'h08, A_CMD = 8'h0C;
    localparam logic [7:0] A_CFG = 8'h10, A_STAT = 8'h14, A_CNT = 8'h18, A_CMP = 8'h1C;
    localparam logic [7:0] A_PER = 8'h20, A_CAPT = 8'h24, A_RAW = 8'h28, A_ISET = 8'h2C;
    localparam logic [7:0] A_MASK = 8'h30, A_MSKD = 8'h34;
    localparam logic [31:0] RUN = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, count_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, irq;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;

    always #2.5 clk = ~clk;

    tcnt_channel u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .count_en   (count_en),
        .irq        (irq)
    );

    // monitor: pops expected items as read data comes back
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        sb.push_back('{e, tag});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic run(input int n);
        @(negedge clk);
        count_en = 1'b1;
        repeat (n) @(negedge clk);
        count_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            report();
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;

        // R14 reset state
        rd(A_ENA,  32'h0, "R14 enable");
        rd(A_CFG,  32'h0, "R14 config");
        rd(A_CNT,  32'h0, "R14 count");
        rd(A_STAT, 32'h0, "R14 status");
        rd(A_PER,  32'hFFFF_FFFF, "R14 period");
        rd(A_CMP,  32'hFFFF_FFFF, "R14 compare");
        rd(A_RAW,  32'h0, "R14 irq raw");
        chk_irq(1'b0, "R14");

        // R2 enable aliases
        wr(A_ESET, 32'h1);
        rd(A_ESET, 32'h1, "R2 set alias reads state");
        rd(A_ECLR, 32'h1, "R2 clear alias reads state");
        rd(A_ENA,  32'h1, "R2 enable on");
        wr(A_ECLR, 32'h1);
        rd(A_ENA,  32'h0, "R2 enable off");
        rd(A_ESET, 32'h0, "R2 set alias off");

        // R3 reload pending, then applied
        wr(A_PER, 32'd5);
        wr(A_CMP, 32'd3);
        wr(A_CMD, 32'h1);
        rd(A_CMD,  32'h1, "R3 reload pending while disabled");
        rd(A_STAT, 32'h0, "R12 not running before reload");
        wr(A_ESET, 32'h1);
        idle(1);
        rd(A_CMD,  32'h0, "R3 reload cleared");
        rd(A_STAT, RUN,   "R3 reload sets running");
        rd(A_CNT,  32'h0, "R3 reload loads 0 in up mode");

        // R4 gated by count_en
        idle(5);
        rd(A_CNT, 32'h0, "R4 count_en low holds count");

        // R5 / R9 up counting, wrap and match
        run(7);
        rd(A_CNT, 32'd1, "R5 up count after 7 steps");
        rd(A_RAW, 32'h3, "R9 match and R5 wrap flags");
        chk_irq(1'b0, "R10 masked off");

        // R10 interrupt views
        wr(A_MASK, 32'h2);
        rd(A_MSKD, 32'h2, "R10 masked view");
        chk_irq(1'b1, "R10 line on match");
        wr(A_RAW, 32'h2);
        rd(A_RAW, 32'h1, "R10 write one clears match only");
        chk_irq(1'b0, "R10 line after clear");
        wr(A_RAW, 32'h1);
        rd(A_RAW, 32'h0, "R10 all clear");
        wr(A_ISET, 32'h1);
        rd(A_RAW,  32'h1, "R10 set register forces tc");
        rd(A_MSKD, 32'h0, "R10 tc masked out");
        wr(A_RAW, 32'h3);
        wr(A_MASK, 32'h0);

        // R4 disabled channel holds
        wr(A_ECLR, 32'h1);
        run(4);
        rd(A_CNT, 32'd1, "R4 disabled holds count");
        wr(A_ESET, 32'h1);

        // R6 down counting
        wr(A_CFG, 32'h10);
        wr(A_CMD, 32'h1);
        idle(1);
        rd(A_CNT,  32'd5, "R3 reload loads period in down mode");
        rd(A_STAT, RUN | 32'h1, "R6 status shows down");
        run(7);
        rd(A_CNT, 32'd4, "R6 down count after 7 steps");
        rd(A_RAW, 32'h3, "R6 underflow and R9 match");
        wr(A_RAW, 32'h3);

        // R8 prescaler, phase-independent windows
        wr(A_CFG, 32'h2);
        wr(A_CMD, 32'h1);
        idle(6);
        rd(A_CNT, 32'd0, "R8 reload at div 4");
        run(8);
        rd(A_CNT, 32'd2, "R8 div 4 over 8 cycles");
        wr(A_CFG, 32'h7);
        wr(A_CMD, 32'h1);
        idle(130);
        rd(A_CNT, 32'd0, "R8 reload at div 128");
        run(256);
        rd(A_CNT, 32'd2, "R8 div 128 over 256 cycles");

        // R11 one-shot
        wr(A_CFG, 32'h100);
        wr(A_PER, 32'd3);
        wr(A_CMD, 32'h1);
        idle(1);
        run(10);
        rd(A_CNT,  32'd3, "R11 one-shot holds at period");
        rd(A_STAT, 32'h0, "R11 one-shot clears running");
        rd(A_RAW,  32'h3, "R11 one-shot tc raised");
        wr(A_RAW, 32'h3);

        // R12 start / stop
        wr(A_CFG, 32'h0);
        wr(A_CMD, 32'h2);
        rd(A_STAT, RUN, "R12 start sets running");
        run(2);
        rd(A_CNT, 32'd1, "R12 counts after start");
        wr(A_CMD, 32'h4);
        rd(A_STAT, 32'h0, "R12 stop clears running");
        run(5);
        rd(A_CNT, 32'd1, "R12 stopped holds count");
        rd(A_CMD, 32'h0, "R12 commands self-clear");

        // R13 capture
        wr(A_CNT, 32'h1234);
        wr(A_CMD, 32'h8);
        rd(A_CAPT, 32'h1234, "R13 capture copies count");
        rd(A_CNT,  32'h1234, "R13 direct count write");

        // R7 up/down, mode 3
        wr(A_RAW, 32'h3);
        wr(A_CMP, 32'd100);
        wr(A_CFG, 32'h30);
        wr(A_CMD, 32'h1);
        idle(1);
        run(5);
        rd(A_CNT,  32'd1, "R7 mode3 after turn at top");
        rd(A_STAT, RUN | 32'h1, "R7 direction down");
        rd(A_RAW,  32'h1, "R7 mode3 tc at top");
        wr(A_RAW, 32'h3);
        run(2);
        rd(A_CNT,  32'd1, "R7 turn at zero");
        rd(A_STAT, RUN, "R7 direction up");
        rd(A_RAW,  32'h1, "R7 tc at zero");
        wr(A_RAW, 32'h3);

        // R7 mode 2: no tc at top
        wr(A_CFG, 32'h20);
        wr(A_CMD, 32'h1);
        idle(1);
        run(4);
        rd(A_CNT, 32'd2, "R7 mode2 count");
        rd(A_RAW, 32'h0, "R7 mode2 no tc at top");

        idle(3);
        if (sb.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R1 reads outstanding actual=%0d expected=0", sb.size());
        end
        done = 1;
        report();
    end

endmodule